// File: doc/BRIEF.md
# Per-Bank Quota SRAM Arbiter

This block shares four independent SRAM banks between two bus masters: a DMA read channel and one other master. Every bank has its own owner register, so the two masters can hold different banks at once. When both ask for an idle bank, the DMA channel wins. The other master gets an idle bank only when the DMA channel is not asking for it.

The DMA channel's claim on a bank is limited by a per-bank quota. A 4-bit field N in a 32-bit configuration word allows the channel 4*N consecutive 32-bit beats on that bank. After the last allowed beat it hands the bank over, but only if the other master is waiting. With no contention it keeps the bank and its count starts again. A field of zero removes the limit for that bank. Once the other master has taken a bank it keeps it until it lowers its request.

A master sees its grant in the cycle after it raises its request. The DMA channel marks each completed 32-bit transfer with a beat-valid pulse. Beat pulses count only while the DMA channel holds that bank.

Top module: `bank_quota_arb`

## Requirements
- R1: After a synchronous reset, the configuration word reads 0x0F0F0F0F. Every quota field holds 15, and no grant is asserted to either master.
- R2: The quota field of bank b sits at bits 8b+3 down to 8b of the configuration word. The upper four bits of each byte always read zero, and writes to them are ignored.
- R3: When a bank is idle and the DMA channel requests it, the DMA channel is granted on the next cycle, even if the other master requests the same bank in the same cycle.
- R4: The quota field N of a bank may be nonzero while the other master requests that bank. The clock edge that takes the DMA channel's 4*N-th consecutive granted beat then moves the grant of that bank to the other master.
- R5: When a bank's quota field is zero, the DMA channel keeps that bank for as long as it requests it, whatever the number of beats.
- R6: When the DMA channel reaches its quota and the other master is not requesting, the DMA channel keeps the grant. Its beat count restarts from zero.
- R7: The DMA channel's beat count for a bank clears when it drops its request or loses the grant. The count starts again from zero at the next grant.
- R8: The other master keeps a bank as long as it requests it. When it drops the request, the bank goes to the DMA channel on the next cycle if that channel is requesting.
- R9: Each bank is arbitrated separately. Different banks may be granted to different masters in the same cycle, and no bank is ever granted to both masters.
- R10: A quota written while the DMA channel owns a bank applies from the next beat. It is compared against the beat count already accumulated.
- R11: DMA beat pulses on a bank that the DMA channel does not hold are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| dma_req | input | 4 | DMA channel request, one bit per bank |
| dma_beat | input | 4 | DMA channel beat-valid, one 32-bit transfer per pulse, per bank |
| dma_gnt | output | 4 | DMA channel grant, per bank |
| oth_req | input | 4 | Other master request, per bank |
| oth_gnt | output | 4 | Other master grant, per bank |

## Verification
A wrong owner state in a bank shows up at once. Both grant outputs come straight from that state, so the first clock after the fault already gives a grant pattern the reference model does not expect. A wrong beat count stays hidden until the quota boundary, where the handover comes early or late by exactly the size of the error. The directed runs therefore place the other master's request so that a count that was not cleared or not restarted, a stray beat that was counted, or a stale limit all move the handover edge by at least one cycle.

// File: rtl/bqa_pkg.sv
package bqa_pkg;
    localparam int NUM_BANKS       = 4;
    localparam int QUOTA_W         = 4;
    localparam int FIELD_STRIDE    = 8;
    localparam int BEAT_SCALE_LOG2 = 2;

    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_DMA  = 2'd1,
        OWN_OTH  = 2'd2
    } owner_e;

    typedef struct packed {
        logic dma_req;
        logic dma_beat;
        logic oth_req;
    } bank_req_t;

    typedef struct packed {
        logic dma_gnt;
        logic oth_gnt;
    } bank_gnt_t;

    function automatic bank_gnt_t decode_owner(owner_e own);
        bank_gnt_t g;
        g.dma_gnt = (own == OWN_DMA);
        g.oth_gnt = (own == OWN_OTH);
        return g;
    endfunction
endpackage

// File: rtl/bqa_cfg_reg.sv
module bqa_cfg_reg #(
    parameter int NB     = 4,
    parameter int QW     = 4,
    parameter int STRIDE = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [NB*STRIDE-1:0]       wdata,
    output logic [NB*STRIDE-1:0]       rdata,
    output logic [NB-1:0][QW-1:0]      quota
);
    logic [NB-1:0][QW-1:0] field_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '1;
        end else if (we) begin
            for (int b = 0; b < NB; b++) begin
                field_q[b] <= wdata[b*STRIDE +: QW];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            rdata[b*STRIDE +: QW] = field_q[b];
        end
    end

    assign quota = field_q;
endmodule

// File: rtl/bqa_bank_arb.sv
module bqa_bank_arb
    import bqa_pkg::*;
#(
    parameter int QW         = 4,
    parameter int SCALE_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [QW-1:0]   quota,
    input  bank_req_t       req,
    output bank_gnt_t       gnt
);
    localparam int CW = QW + SCALE_LOG2 + 1;

    owner_e         own_q, own_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [CW-1:0]  limit;
    logic           unlimited;
    logic           beat_ok;
    logic           quota_hit;

    assign limit     = {1'b0, quota, {SCALE_LOG2{1'b0}}};
    assign unlimited = (quota == '0);
    assign beat_ok   = (own_q == OWN_DMA) && req.dma_beat;
    assign quota_hit = beat_ok && !unlimited && ((cnt_q + 1'b1) >= limit);

    always_comb begin
        own_d = own_q;
        cnt_d = cnt_q;
        unique case (own_q)
            OWN_IDLE: begin
                cnt_d = '0;
                if (req.dma_req)      own_d = OWN_DMA;
                else if (req.oth_req) own_d = OWN_OTH;
            end
            OWN_DMA: begin
                if (!req.dma_req) begin
                    cnt_d = '0;
                    own_d = req.oth_req ? OWN_OTH : OWN_IDLE;
                end else if (quota_hit) begin
                    cnt_d = '0;
                    if (req.oth_req) own_d = OWN_OTH;
                end else if (beat_ok && !unlimited) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            OWN_OTH: begin
                cnt_d = '0;
                if (!req.oth_req) own_d = req.dma_req ? OWN_DMA : OWN_IDLE;
            end
            default: begin
                cnt_d = '0;
                own_d = OWN_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= OWN_IDLE;
            cnt_q <= '0;
        end else begin
            own_q <= own_d;
            cnt_q <= cnt_d;
        end
    end

    assign gnt = decode_owner(own_q);
endmodule

// File: rtl/bank_quota_arb.sv
module bank_quota_arb
    import bqa_pkg::*;
#(
    parameter int NB         = NUM_BANKS,
    parameter int QW         = QUOTA_W,
    parameter int STRIDE     = FIELD_STRIDE,
    parameter int SCALE_LOG2 = BEAT_SCALE_LOG2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [NB*STRIDE-1:0]   cfg_wdata,
    output logic [NB*STRIDE-1:0]   cfg_rdata,
    input  logic [NB-1:0]          dma_req,
    input  logic [NB-1:0]          dma_beat,
    output logic [NB-1:0]          dma_gnt,
    input  logic [NB-1:0]          oth_req,
    output logic [NB-1:0]          oth_gnt
);
    logic [NB-1:0][QW-1:0] quota;

    bqa_cfg_reg #(.NB(NB), .QW(QW), .STRIDE(STRIDE)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .quota (quota)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        bank_req_t breq;
        bank_gnt_t bgnt;

        assign breq.dma_req  = dma_req[b];
        assign breq.dma_beat = dma_beat[b];
        assign breq.oth_req  = oth_req[b];

        bqa_bank_arb #(.QW(QW), .SCALE_LOG2(SCALE_LOG2)) u_arb (
            .clk   (clk),
            .rst   (rst),
            .quota (quota[b]),
            .req   (breq),
            .gnt   (bgnt)
        );

        assign dma_gnt[b] = bgnt.dma_gnt;
        assign oth_gnt[b] = bgnt.oth_gnt;
    end
endmodule

// File: rtl/bqa_checker.sv
module bqa_checker #(
    parameter int NB     = 4,
    parameter int QW     = 4,
    parameter int STRIDE = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NB*STRIDE-1:0] cfg_rdata,
    input logic [NB-1:0]        dma_req,
    input logic [NB-1:0]        dma_gnt,
    input logic [NB-1:0]        oth_req,
    input logic [NB-1:0]        oth_gnt
);
    for (genvar b = 0; b < NB; b++) begin : g_chk
        AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
            !(dma_gnt[b] && oth_gnt[b])); // R9

        AST_IDLE_DMA_WINS: assert property (@(posedge clk) disable iff (rst)
            (!dma_gnt[b] && !oth_gnt[b] && dma_req[b]) |=> dma_gnt[b]); // R3

        AST_DMA_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
            $rose(dma_gnt[b]) |-> $past(dma_req[b])); // R3

        AST_OTH_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (oth_gnt[b] && oth_req[b]) |=> oth_gnt[b]); // R8

        AST_OTH_RETURNS: assert property (@(posedge clk) disable iff (rst)
            (oth_gnt[b] && !oth_req[b] && dma_req[b]) |=> dma_gnt[b]); // R8

        AST_UNLIMITED_KEEP: assert property (@(posedge clk) disable iff (rst)
            (dma_gnt[b] && dma_req[b] && (cfg_rdata[b*STRIDE +: QW] == '0)) |=> dma_gnt[b]); // R5

        AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
            cfg_rdata[b*STRIDE+QW +: STRIDE-QW] == '0); // R2
    end
endmodule

bind bank_quota_arb bqa_checker #(.NB(NB), .QW(QW), .STRIDE(STRIDE)) u_bqa_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .dma_req   (dma_req),
    .dma_gnt   (dma_gnt),
    .oth_req   (oth_req),
    .oth_gnt   (oth_gnt)
);

// File: tb/test_bank_quota_arb.sv
`timescale 1ns/1ps
module test_bank_quota_arb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [3:0]  dma_req, dma_beat, dma_gnt, oth_req, oth_gnt;

    always #2.5 clk = ~clk;

    bank_quota_arb i_bank_quota_arb (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dma_req(dma_req), .dma_beat(dma_beat),
        .dma_gnt(dma_gnt), .oth_req(oth_req), .oth_gnt(oth_gnt)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference: 0 idle, 1 dma, 2 other
    int          m_own [4];
    int          m_cnt [4];
    logic [31:0] m_cfg;
    int          m_n, m_lim;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 4; b++) begin m_own[b] = 0; m_cnt[b] = 0; end
            m_cfg = 32'h0F0F_0F0F;
        end else begin
            for (int b = 0; b < 4; b++) begin
                m_n   = (m_cfg >> (8*b)) & 15;
                m_lim = 4 * m_n;
                if (m_own[b] == 0) begin
                    m_cnt[b] = 0;
                    if (dma_req[b]) m_own[b] = 1;
                    else if (oth_req[b]) m_own[b] = 2;
                end else if (m_own[b] == 1) begin
                    if (!dma_req[b]) begin
                        m_cnt[b] = 0;
                        m_own[b] = oth_req[b] ? 2 : 0;
                    end else if (dma_beat[b] && m_n != 0) begin
                        m_cnt[b]++;
                        if (m_cnt[b] >= m_lim) begin
                            m_cnt[b] = 0;
                            if (oth_req[b]) m_own[b] = 2;
                        end
                    end
                end else begin
                    m_cnt[b] = 0;
                    if (!oth_req[b]) m_own[b] = dma_req[b] ? 1 : 0;
                end
            end
            if (cfg_we) m_cfg = cfg_wdata & 32'h0F0F_0F0F;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] eg;
            for (int b = 0; b < 4; b++) begin
                eg[b]   = (m_own[b] == 1);
                eg[b+4] = (m_own[b] == 2);
            end
            chk("R9 model grants", {24'h0, oth_gnt, dma_gnt}, {24'h0, eg});
            chk("R2 model cfg", cfg_rdata, m_cfg);
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic write_cfg(logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick(1);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        done = 1;
        finish_report();
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_wdata = '0;
        dma_req = '0; dma_beat = '0; oth_req = '0;
        tick(3);
        chk("R1 reset cfg", cfg_rdata, 32'h0F0F_0F0F);
        chk("R1 reset grants", {24'h0, oth_gnt, dma_gnt}, 32'h0);
        rst = 0;

        write_cfg(32'hFFFF_FFFF);
        chk("R2 reserved ignored", cfg_rdata, 32'h0F0F_0F0F);
        write_cfg(32'hA5C3_7E19);
        chk("R2 masked write", cfg_rdata, 32'h0503_0E09);

        write_cfg(32'h0F0F_0F01);   // bank0 quota 4 beats
        dma_req[0] = 1; oth_req[0] = 1;
        tick(1);
        chk("R3 dma wins idle", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);

        dma_beat[0] = 1;
        tick(3);
        chk("R4 before quota", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);
        tick(1);
        chk("R4 yield at quota", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h2);
        dma_beat[0] = 0;

        tick(3);
        chk("R8 other holds", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h2);
        oth_req[0] = 0;
        tick(1);
        chk("R8 return to dma", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);

        dma_beat[0] = 1;
        tick(4);
        chk("R6 keep without contention", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);
        oth_req[0] = 1;
        tick(3);
        chk("R6 count restarted", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);
        tick(1);
        chk("R6 yield after restart", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h2);

        tick(5);                    // beats while not granted
        dma_beat[0] = 0; oth_req[0] = 0;
        tick(1);
        oth_req[0] = 1; dma_beat[0] = 1;
        tick(3);
        chk("R11 stray beats ignored", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);
        tick(1);
        chk("R11 yield at quota", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h2);
        dma_beat[0] = 0;

        oth_req[0] = 0;
        tick(1);
        dma_beat[0] = 1;
        tick(2);
        dma_beat[0] = 0; dma_req[0] = 0;
        tick(1);
        chk("R7 drop request idles", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h0);
        dma_req[0] = 1; oth_req[0] = 1;
        tick(1);
        dma_beat[0] = 1;
        tick(3);
        chk("R7 count cleared", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);
        tick(1);
        chk("R7 yield from zero", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h2);
        dma_beat[0] = 0;

        oth_req[0] = 0;
        write_cfg(32'h0F0F_0F02);   // quota 8
        oth_req[0] = 1; dma_beat[0] = 1;
        tick(3);
        dma_beat[0] = 0;
        write_cfg(32'h0F0F_0F01);   // quota 4 with count 3
        chk("R10 still dma", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);
        dma_beat[0] = 1;
        tick(1);
        chk("R10 new quota applied", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h2);
        dma_beat[0] = 0;

        oth_req[0] = 0;
        write_cfg(32'h0F0F_0F00);   // unlimited
        oth_req[0] = 1; dma_beat[0] = 1;
        tick(70);
        chk("R5 unlimited ownership", {30'h0, oth_gnt[0], dma_gnt[0]}, 32'h1);
        dma_beat[0] = 0; dma_req[0] = 0; oth_req[0] = 0;
        tick(2);

        dma_req = 4'b0101; oth_req = 4'b0110;
        tick(1);
        chk("R9 dma grants per bank", {28'h0, dma_gnt}, 32'h5);
        chk("R9 other grants per bank", {28'h0, oth_gnt}, 32'h2);
        dma_req = '0; oth_req = '0;
        tick(2);
        chk("R9 all released", {24'h0, oth_gnt, dma_gnt}, 32'h0);

        done = 1;
        finish_report();
    end
endmodule